// File: doc/BRIEF.md
# Cascadable LCD Column Driver Core

This block is the logic core of a dot-matrix LCD column driver. Display data arrives as 4-bit words on a valid/ready stream. Each accepted word is written into the next 4-bit slot of an 80-bit fill register, and a direction input picks the order in which the slots fill. A load strobe copies the fill register into an output latch. Each of the 80 latched bits then becomes a 2-bit drive-level code, shaped by the frame alternation input and an active-low blanking input.

Several cores can share one data bus in a chain. A core accepts words only while its chain-enable input is low and its own line is not yet complete. Once its last slot is written, it drops its chain-enable output, and the next core in the chain takes the bus. The direction input also decides which of the two chain pin pairs acts as the enable input and which as the enable output.

Stream rules: a word transfers on a rising clock edge where `nib_valid` and `nib_ready` are both high. `nib_ready` is low while the chain-enable input is high, while the line is full, and during a load strobe. A word offered while `nib_ready` is low is not taken. Every core on a shared bus sees the same valid and data, and at most one core in the chain is ready at a time.

Top module: `lcdseg_driver`

## Requirements
- R1: A word is accepted only on a cycle with `nib_valid` and `nib_ready` both high. `nib_ready` is low whenever `latch_stb` is high, and each accepted word advances the word count by one.
- R2: With `dir_rl` low, `cas_r_in` is the active-low chain enable and `cas_l_out` is the chain output, while `cas_r_out` is held high. With `dir_rl` high, `cas_l_in` is the enable, `cas_r_out` is the output, and `cas_l_out` is held high.
- R3: After 20 words are accepted since the last reset or load, the core is full: `nib_ready` stays low and the selected chain output goes low.
- R4: The k-th accepted word of a line (k = 0..19) goes to slot k when `dir_rl` is high, and to slot 19-k when `dir_rl` is low. Bit i of the word lands in segment 4*slot+i.
- R5: A cycle with `latch_stb` high copies the fill register into the latch, so the level codes change after that clock edge. The same edge clears the word count and the full flag, which drives both chain outputs high.
- R6: With `blank_n` high, segment s gives code {M, ~(M xor Q)}, where Q is the latched bit and M is `alt_m`. The codes are V1=00, V3=01, V4=10 and VEE=11: M=0,Q=0 gives 01; M=0,Q=1 gives 00; M=1,Q=0 gives 10; M=1,Q=1 gives 11.
- R7: With `blank_n` low, every segment gives code 00, whatever the latch and `alt_m` hold.
- R8: A synchronous active-low reset clears the fill register, the latch, the word count and the full flag. After reset, with `blank_n` high and `alt_m` low, every segment gives 01.
- R9: A word offered while `nib_ready` is low leaves the fill register unchanged. This is seen in the level codes after the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| dir_rl | input | 1 | Fill order and chain pin selection |
| nib_valid | input | 1 | Data word valid |
| nib_data | input | 4 | Data word |
| nib_ready | output | 1 | Core accepts a word this cycle |
| cas_r_in | input | 1 | Chain enable input (active low) when dir_rl is low |
| cas_l_in | input | 1 | Chain enable input (active low) when dir_rl is high |
| cas_r_out | output | 1 | Chain output when dir_rl is high, otherwise held high |
| cas_l_out | output | 1 | Chain output when dir_rl is low, otherwise held high |
| latch_stb | input | 1 | Load strobe, one cycle |
| alt_m | input | 1 | Frame alternation signal |
| blank_n | input | 1 | Display blanking, active low |
| level_code | output | 160 | 2-bit level code per segment, segment s at bits 2s+1:2s |

## Verification
The assertions assume that `dir_rl` changes only right after a load or a reset, never in the middle of a line, so that the chain outputs and the word count describe a single line. They also assume that `latch_stb` is a plain synchronous pulse. The stimulus changes direction only between lines, after a load. It drives every input on the falling clock edge, and it runs two chained cores on one shared bus, so that the ready handover between them is exercised in both directions.

// File: rtl/lcdseg_pkg.sv
package lcdseg_pkg;

  typedef enum logic [1:0] {
    LV_V1  = 2'b00,
    LV_V3  = 2'b01,
    LV_V4  = 2'b10,
    LV_VEE = 2'b11
  } lvl_e;

  // Drive level for one segment from alternation, latched bit and blanking.
  function automatic lvl_e seg_level(input logic m, input logic q, input logic blank_n);
    lvl_e lv;
    if (!blank_n)    lv = LV_V1;
    else if (!m)     lv = q ? LV_V1 : LV_V3;
    else             lv = q ? LV_VEE : LV_V4;
    return lv;
  endfunction

endpackage

// File: rtl/lcdseg_chain_ctl.sv
module lcdseg_chain_ctl #(
  parameter int NIBBLES = 20,
  parameter int CW      = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dir_rl,
  input  logic          cas_r_in,
  input  logic          cas_l_in,
  input  logic          nib_valid,
  input  logic          latch_stb,
  output logic          nib_ready,
  output logic          accept,
  output logic [CW-1:0] cnt,
  output logic          cas_r_out,
  output logic          cas_l_out
);

  localparam logic [CW-1:0] LAST = CW'(NIBBLES - 1);

  logic en_n;
  logic full;

  // Direction picks which chain pin is the enable input.
  assign en_n      = dir_rl ? cas_l_in : cas_r_in;
  assign nib_ready = !en_n && !full && !latch_stb;
  assign accept    = nib_ready && nib_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      full <= 1'b0;
    end else if (latch_stb) begin
      cnt  <= '0;
      full <= 1'b0;
    end else if (accept) begin
      cnt <= cnt + 1'b1;
      if (cnt == LAST) full <= 1'b1;
    end
  end

  // The unused pin of the pair stays inactive (high).
  assign cas_l_out = dir_rl ? 1'b1 : !full;
  assign cas_r_out = dir_rl ? !full : 1'b1;

endmodule

// File: rtl/lcdseg_fill.sv
module lcdseg_fill #(
  parameter int NSEG    = 80,
  parameter int DW      = 4,
  parameter int NIBBLES = 20,
  parameter int CW      = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept,
  input  logic            dir_rl,
  input  logic [CW-1:0]   cnt,
  input  logic [DW-1:0]   nib_data,
  output logic [NSEG-1:0] fill_q
);

  localparam logic [CW-1:0] TOP_SLOT = CW'(NIBBLES - 1);

  logic [CW-1:0] slot;

  // Ascending order for one direction, mirrored for the other.
  assign slot = dir_rl ? cnt : (TOP_SLOT - cnt);

  for (genvar g = 0; g < NIBBLES; g++) begin : g_slot
    logic [DW-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)                          q <= '0;
      else if (accept && slot == CW'(g))   q <= nib_data;
    end
    assign fill_q[g*DW +: DW] = q;
  end

endmodule

// File: rtl/lcdseg_latch_enc.sv
module lcdseg_latch_enc
  import lcdseg_pkg::*;
#(
  parameter int NSEG = 80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              latch_stb,
  input  logic [NSEG-1:0]   fill_q,
  input  logic              alt_m,
  input  logic              blank_n,
  output logic [2*NSEG-1:0] level_code
);

  logic [NSEG-1:0] held;

  always_ff @(posedge clk) begin
    if (!rst_n)         held <= '0;
    else if (latch_stb) held <= fill_q;
  end

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    assign level_code[2*s +: 2] = seg_level(alt_m, held[s], blank_n);
  end

endmodule

// File: rtl/lcdseg_driver.sv
module lcdseg_driver #(
  parameter int NSEG = 80,
  parameter int DW   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dir_rl,
  input  logic              nib_valid,
  input  logic [DW-1:0]     nib_data,
  output logic              nib_ready,
  input  logic              cas_r_in,
  input  logic              cas_l_in,
  output logic              cas_r_out,
  output logic              cas_l_out,
  input  logic              latch_stb,
  input  logic              alt_m,
  input  logic              blank_n,
  output logic [2*NSEG-1:0] level_code
);

  localparam int NIBBLES = NSEG / DW;
  localparam int CW      = $clog2(NIBBLES + 1);

  logic            accept;
  logic [CW-1:0]   nib_cnt;
  logic [NSEG-1:0] fill_q;

  lcdseg_chain_ctl #(.NIBBLES(NIBBLES), .CW(CW)) u_ctl (
    .clk(clk), .rst_n(rst_n), .dir_rl(dir_rl),
    .cas_r_in(cas_r_in), .cas_l_in(cas_l_in),
    .nib_valid(nib_valid), .latch_stb(latch_stb),
    .nib_ready(nib_ready), .accept(accept), .cnt(nib_cnt),
    .cas_r_out(cas_r_out), .cas_l_out(cas_l_out)
  );

  lcdseg_fill #(.NSEG(NSEG), .DW(DW), .NIBBLES(NIBBLES), .CW(CW)) u_fill (
    .clk(clk), .rst_n(rst_n), .accept(accept), .dir_rl(dir_rl),
    .cnt(nib_cnt), .nib_data(nib_data), .fill_q(fill_q)
  );

  lcdseg_latch_enc #(.NSEG(NSEG)) u_enc (
    .clk(clk), .rst_n(rst_n), .latch_stb(latch_stb), .fill_q(fill_q),
    .alt_m(alt_m), .blank_n(blank_n), .level_code(level_code)
  );

endmodule

// File: rtl/lcdseg_driver_chk.sv
module lcdseg_driver_chk #(
  parameter int NSEG = 80,
  parameter int DW   = 4,
  parameter int CW   = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dir_rl,
  input logic              nib_valid,
  input logic              nib_ready,
  input logic              cas_r_out,
  input logic              cas_l_out,
  input logic              latch_stb,
  input logic              blank_n,
  input logic [2*NSEG-1:0] level_code,
  input logic [CW-1:0]     nib_cnt
);

  localparam int NIBBLES = NSEG / DW;

  logic sel_out;
  assign sel_out = dir_rl ? cas_r_out : cas_l_out;

  p_no_ready_on_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    latch_stb |-> !nib_ready);

  p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (nib_valid && nib_ready) |=> nib_cnt == CW'($past(nib_cnt) + 1'b1));

  p_idle_pin_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dir_rl ? cas_l_out : cas_r_out);

  p_full_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_out |-> !nib_ready);

  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    nib_cnt <= CW'(NIBBLES));

  p_load_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    latch_stb |=> (nib_cnt == '0 && cas_r_out && cas_l_out));

  p_blank_forces_v1_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !blank_n |-> level_code == '0);

endmodule

bind lcdseg_driver lcdseg_driver_chk #(.NSEG(NSEG), .DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .dir_rl(dir_rl), .nib_valid(nib_valid),
  .nib_ready(nib_ready), .cas_r_out(cas_r_out), .cas_l_out(cas_l_out),
  .latch_stb(latch_stb), .blank_n(blank_n), .level_code(level_code),
  .nib_cnt(nib_cnt)
);

// File: tb/lcdseg_driver_test.sv
module lcdseg_driver_test;

  localparam int CLK_P   = 10;
  localparam int NSEG    = 80;
  localparam int DW      = 4;
  localparam int NIBBLES = NSEG / DW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dir_rl = 1'b0;
  logic nib_valid = 1'b0;
  logic [DW-1:0] nib_data = '0;
  logic latch_stb = 1'b0;
  logic alt_m = 1'b0;
  logic blank_n = 1'b1;

  logic a_rdy, b_rdy;
  logic a_r_in, a_l_in, a_r_out, a_l_out;
  logic b_r_in, b_l_in, b_r_out, b_l_out;
  logic [2*NSEG-1:0] a_code, b_code;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  // Head of chain always enabled on its selected input; second core follows it.
  assign a_r_in = dir_rl ? 1'b1 : 1'b0;
  assign a_l_in = dir_rl ? 1'b0 : 1'b1;
  assign b_r_in = dir_rl ? 1'b1 : a_l_out;
  assign b_l_in = dir_rl ? a_r_out : 1'b1;

  lcdseg_driver #(.NSEG(NSEG), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .dir_rl(dir_rl), .nib_valid(nib_valid),
    .nib_data(nib_data), .nib_ready(a_rdy), .cas_r_in(a_r_in), .cas_l_in(a_l_in),
    .cas_r_out(a_r_out), .cas_l_out(a_l_out), .latch_stb(latch_stb),
    .alt_m(alt_m), .blank_n(blank_n), .level_code(a_code)
  );

  lcdseg_driver #(.NSEG(NSEG), .DW(DW)) uut_b (
    .clk(clk), .rst_n(rst_n), .dir_rl(dir_rl), .nib_valid(nib_valid),
    .nib_data(nib_data), .nib_ready(b_rdy), .cas_r_in(b_r_in), .cas_l_in(b_l_in),
    .cas_r_out(b_r_out), .cas_l_out(b_l_out), .latch_stb(latch_stb),
    .alt_m(alt_m), .blank_n(blank_n), .level_code(b_code)
  );

  function automatic logic [DW-1:0] word_val(input int j, input int seed);
    return DW'((j * 7 + seed * 3 + 1) % 16);
  endfunction

  // Expected codes for one chip of the pair, from R4, R6, R7.
  function automatic logic [2*NSEG-1:0] exp_codes(input int chip, input bit dir,
      input int seed, input bit m, input bit bl_n);
    logic [2*NSEG-1:0] v = '0;
    for (int s = 0; s < NSEG; s++) begin
      int slot = s / DW;
      int k = dir ? slot : (NIBBLES - 1 - slot);
      logic [DW-1:0] w = word_val(chip * NIBBLES + k, seed);
      logic q = w[s % DW];
      v[2*s +: 2] = bl_n ? {m, ~(m ^ q)} : 2'b00;
    end
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [2*NSEG-1:0] act,
      input logic [2*NSEG-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_line(input bit dir, input int seed);
    @(negedge clk);
    dir_rl = dir;
    #1;
    chk(a_rdy == 1'b1 && b_rdy == 1'b0, "R2 head ready only", {a_rdy, b_rdy}, 2'b10);
    for (int j = 0; j < 2 * NIBBLES; j++) begin
      if (j == NIBBLES) begin
        #1;
        chk(a_rdy == 1'b0 && b_rdy == 1'b1, "R3 handover", {a_rdy, b_rdy}, 2'b01);
      end
      nib_valid = 1'b1;
      nib_data = word_val(j, seed);
      @(negedge clk);
    end
    #1;
    chk(a_rdy == 1'b0 && b_rdy == 1'b0, "R3 both full", {a_rdy, b_rdy}, 2'b00);
    if (dir) chk(b_r_out == 1'b0 && b_l_out == 1'b1, "R2 R3 chain out dir1", {b_r_out, b_l_out}, 2'b01);
    else     chk(b_l_out == 1'b0 && b_r_out == 1'b1, "R2 R3 chain out dir0", {b_l_out, b_r_out}, 2'b01);
    // Extra word while not ready (R9)
    nib_data = 4'hF;
    @(negedge clk);
    nib_valid = 1'b0;
    latch_stb = 1'b1;
    #1;
    chk(a_rdy == 1'b0, "R1 not ready during load", a_rdy, 1'b0);
    @(negedge clk);
    latch_stb = 1'b0;
    alt_m = 1'b0;
    blank_n = 1'b1;
    #1;
    chk(a_code == exp_codes(0, dir, seed, 0, 1), "R4 R6 R9 chip0 m0", a_code, exp_codes(0, dir, seed, 0, 1));
    chk(b_code == exp_codes(1, dir, seed, 0, 1), "R4 R6 R9 chip1 m0", b_code, exp_codes(1, dir, seed, 0, 1));
    chk(a_rdy == 1'b1 && a_r_out && a_l_out, "R5 load clears", {a_rdy, a_r_out, a_l_out}, 3'b111);
    alt_m = 1'b1;
    #1;
    chk(a_code == exp_codes(0, dir, seed, 1, 1), "R6 chip0 m1", a_code, exp_codes(0, dir, seed, 1, 1));
    chk(b_code == exp_codes(1, dir, seed, 1, 1), "R6 chip1 m1", b_code, exp_codes(1, dir, seed, 1, 1));
    blank_n = 1'b0;
    #1;
    chk(a_code == '0 && b_code == '0, "R7 blank", a_code | b_code, '0);
    blank_n = 1'b1;
    alt_m = 1'b0;
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [2*NSEG-1:0] rst_exp;
    for (int s = 0; s < NSEG; s++) rst_exp[2*s +: 2] = 2'b01;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(a_code == rst_exp && b_code == rst_exp, "R8 reset codes", a_code, rst_exp);
    chk(a_l_out && a_r_out, "R8 R2 reset chain outs", {a_l_out, a_r_out}, 2'b11);
    // Load strobe with a valid word offered: nothing taken (R1)
    @(negedge clk);
    nib_valid = 1'b1;
    nib_data = 4'h9;
    latch_stb = 1'b1;
    #1;
    chk(a_rdy == 1'b0 && b_rdy == 1'b0, "R1 strobe blocks ready", {a_rdy, b_rdy}, 2'b00);
    @(negedge clk);
    nib_valid = 1'b0;
    latch_stb = 1'b0;
    for (int d = 0; d < 2; d++)
      for (int sd = 0; sd < 3; sd++)
        run_line(d[0], sd + d * 5);
    run_line(1'b0, 11);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule